// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a countdown watchdog reached through a 32-bit word register interface. Software loads a reload value, enables the countdown through the control register and must keep it alive by writing a 16-bit key to the restart register. If the counter runs out first, the block raises a one-cycle reset request and optionally sets a sticky interrupt flag.

The countdown advances on a slow tick. The tick comes from an internal prescaler that divides the fast peripheral clock, and this variant always selects it. An external flag that reports the memory controller held in reset turns an expiry into a silent stop that clears the control register. A separate 32-bit key, written to its own command word, requests an immediate reset, but only while the reset-mode field selects the SoC-level reset.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter and the reload register both read 0x014FB180, the control register reads 0x00000010, the countdown is stopped and both outputs are low.
- R2: Reads are combinational on `rdata` for the word at `req_addr[7:2]`: byte offset 0x00 is the counter, 0x04 the reload value and 0x0C the control register. The restart word at 0x08, the command word at 0x24 and every other offset read 0.
- R3: A write to offset 0x08 whose low 16 bits equal 0x4755 copies the reload value into the counter, clears the prescaler and the interrupt flag, and resumes counting if enable (control bit 0) is set. A write with any other value changes nothing.
- R4: A control write that takes enable from 0 to 1 loads the counter from the reload value, clears the prescaler and starts the countdown.
- R5: A control write that takes enable from 1 to 0 stops the countdown, and the counter then holds its value.
- R6: Every control write stores the data with bits 11:8 forced to 0 and bit 4 (tick select) forced to 1.
- R7: While counting, the counter drops by one every DIV clock cycles (default 24), the first step coming DIV cycles after the start.
- R8: With reload N >= 1, the expiry comes N*DIV cycles after the start. The counter becomes 0 and counting stops. If control bit 1 is set, `rst_req` is high for exactly one cycle, and if control bit 2 is set, `irq` goes high and stays high until a valid restart.
- R9: If `mem_in_reset` is high at expiry, no reset request and no interrupt are raised, and the control register becomes 0.
- R10: Writing exactly 0xAEEDF123 to offset 0x24 pulses `rst_req` in the next cycle, but only when control bits 6:5 equal 0. Any other value, or any other mode, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset; bits 7:2 select the word |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| mem_in_reset | input | 1 | Memory controller in reset; suppresses expiry |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Sticky interrupt request |

## Verification
The countdown is run with random reload values, random control bits and random levels of `mem_in_reset`. The counter is sampled at a random point during each run, which separates a wrong tick rate from a wrong first step. The exact cycle of the reset pulse is checked, together with the pulse and interrupt gating by control bits 1 and 2, which shows whether the expiry rule is off by one tick. Directed cases cover wrong restart and command keys, the non-SoC reset mode, the forced control bits and a counter that holds after a disable.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int          DIV       = 24,
  parameter logic [31:0] RST_COUNT = 32'h014F_B180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rdata,
  input  logic        mem_in_reset,
  output logic        rst_req,
  output logic        irq
);
  localparam int          PW        = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
  localparam logic [5:0]  W_CNT     = 6'h00;
  localparam logic [5:0]  W_RELOAD  = 6'h01;
  localparam logic [5:0]  W_KICK    = 6'h02;
  localparam logic [5:0]  W_CTRL    = 6'h03;
  localparam logic [5:0]  W_SWRST   = 6'h09;
  localparam logic [15:0] KICK_KEY  = 16'h4755;
  localparam logic [31:0] SWRST_KEY = 32'hAEED_F123;
  localparam logic [31:0] CTRL_INIT = 32'h0000_0010;

  logic [31:0]   cnt, reload, ctrl;
  logic [PW-1:0] pre;
  logic          running;

  wire        wr       = req_valid & req_write;
  wire [5:0]  word     = req_addr[7:2];
  wire [31:0] ctrl_new = (req_wdata & ~32'h0000_0F00) | 32'h0000_0010;
  wire        tick     = running && (pre == PRE_LAST);
  wire        expire   = tick && (cnt <= 32'd1);
  wire        kick_ok  = wr && word == W_KICK && req_wdata[15:0] == KICK_KEY;

  always_comb begin
    case (word)
      W_CNT:    rdata = cnt;
      W_RELOAD: rdata = reload;
      W_CTRL:   rdata = ctrl;
      default:  rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= RST_COUNT;
      reload  <= RST_COUNT;
      ctrl    <= CTRL_INIT;
      pre     <= '0;
      running <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (running) pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        if (expire) begin
          cnt     <= 32'h0;
          running <= 1'b0;
          if (mem_in_reset) ctrl <= 32'h0;
          else begin
            rst_req <= ctrl[1];
            irq     <= irq | ctrl[2];
          end
        end else begin
          cnt <= cnt - 32'd1;
        end
      end
      if (wr) begin
        case (word)
          W_RELOAD: reload <= req_wdata;
          W_KICK: if (req_wdata[15:0] == KICK_KEY) begin
            cnt     <= reload;
            pre     <= '0;
            running <= ctrl[0];
            irq     <= 1'b0;
          end
          W_CTRL: begin
            ctrl <= ctrl_new;
            if (ctrl_new[0] && !ctrl[0]) begin
              cnt     <= reload;
              pre     <= '0;
              running <= 1'b1;
            end else if (!ctrl_new[0] && ctrl[0]) begin
              running <= 1'b0;
            end
          end
          W_SWRST: if (req_wdata == SWRST_KEY && ctrl[6:5] == 2'b00) rst_req <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_ctrl_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 32'h0) || (ctrl[4] && ctrl[11:8] == 4'h0));

  p_kick_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> cnt == $past(reload));

  p_disable_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_CTRL && !req_wdata[0]) |=> !running);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt > 32'd1 && !wr) |=> cnt == $past(cnt) - 32'd1);

  p_mem_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mem_in_reset && !wr) |=> (ctrl == 32'h0 && !rst_req && !running));
endmodule

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int DIV = 24;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, mem_in_reset = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rdata;
  logic rst_req, irq;
  int n_chk = 0, n_bad = 0;

  wdt_keyed #(.DIV(DIV)) dut_i (.clk, .rst_n, .req_valid, .req_write, .req_addr,
    .req_wdata, .rdata, .mem_in_reset, .rst_req, .irq);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_cnt(int n, int m);
    return 32'(n - m / DIV);
  endfunction

  function automatic logic [31:0] exp_ctrl(logic [31:0] d);
    return (d & ~32'h0F00) | 32'h10;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req_addr = a; #1 d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd1234));
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 cnt", v, 32'h014FB180);
    rd(8'h04, v); chk("R1 reload", v, 32'h014FB180);
    rd(8'h0C, v); chk("R1 ctrl", v, 32'h10);
    chk("R1 outputs", {30'h0, rst_req, irq}, 32'h0);
    // R2 unmapped reads
    rd(8'h08, v); chk("R2 restart word", v, 0);
    rd(8'h24, v); chk("R2 command word", v, 0);
    rd(8'h10, v); chk("R2 unmapped", v, 0);
    // R6 forced bits, non-SoC mode
    wr(8'h0C, 32'h0000_FFF0);
    rd(8'h0C, v); chk("R6 ctrl sanitize", v, exp_ctrl(32'h0000_FFF0));
    // R10 key ignored in mode 3
    wr(8'h24, 32'hAEEDF123); chk("R10 mode ignore", {31'h0, rst_req}, 0);
    cyc(1);             chk("R10 mode ignore+1", {31'h0, rst_req}, 0);
    wr(8'h0C, 32'h0);
    rd(8'h0C, v); chk("R6 ctrl zero", v, 32'h10);
    wr(8'h24, 32'hAEEDF124); chk("R10 wrong key", {31'h0, rst_req}, 0);
    wr(8'h24, 32'hAEEDF123); chk("R10 pulse", {31'h0, rst_req}, 1);
    cyc(1);             chk("R10 pulse end", {31'h0, rst_req}, 0);
    // R3 restart keys
    wr(8'h04, 32'd5);
    wr(8'h08, 32'h0000_1234); rd(8'h00, v); chk("R3 bad key", v, 32'h014FB180);
    wr(8'h08, 32'hABCD_4755); rd(8'h00, v); chk("R3 good key", v, 32'd5);
    cyc(3 * DIV); rd(8'h00, v); chk("R3 no run when disabled", v, 32'd5);
    // R4/R5 start then disable hold
    wr(8'h0C, 32'h1); cyc(2 * DIV + 3);
    rd(8'h00, v); chk("R4 start count", v, exp_cnt(5, 2 * DIV + 3));
    wr(8'h0C, 32'h0); rd(8'h00, v);
    cyc(4 * DIV); rd(8'h00, v2); chk("R5 hold", v2, v);
    // random runs
    for (int it = 0; it < 24; it++) begin
      int n = 2 + int'($urandom_range(0, 4));
      int m = int'($urandom_range(0, n * DIV - 1));
      logic [2:0] cb = 3'($urandom_range(0, 7));
      logic mr = ($urandom_range(0, 3) == 0);
      logic [31:0] cval = {25'h0, 2'b00, 1'b0, cb[2], cb[1], 1'b1} | (32'($urandom_range(0, 15)) << 8);
      wr(8'h04, 32'(n));
      mem_in_reset = mr;
      wr(8'h0C, cval);
      cyc(m);
      rd(8'h00, v); chk("R7 mid count", v, exp_cnt(n, m));
      cyc(n * DIV - 1 - m);
      chk("R8 no early pulse", {31'h0, rst_req}, 0);
      cyc(1);
      chk("R8 pulse", {31'h0, rst_req}, {31'h0, cval[1] & ~mr});
      chk("R8 irq", {31'h0, irq}, {31'h0, cval[2] & ~mr});
      rd(8'h00, v); chk("R8 counter zero", v, 0);
      rd(8'h0C, v); chk("R9 ctrl after expiry", v, mr ? 32'h0 : exp_ctrl(cval));
      cyc(1);
      chk("R8 pulse single", {31'h0, rst_req}, 0);
      cyc(DIV + 2); rd(8'h00, v); chk("R8 stopped", v, 0);
      mem_in_reset = 0;
      wr(8'h0C, 32'h0);
      wr(8'h08, 32'h4755);
      chk("R3 irq cleared", {31'h0, irq}, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule